// File: doc/BRIEF.md
# SHA-512 Message Schedule Unit

This block computes four new 64-bit words of the SHA-512 message schedule per operation, split into two selectable steps. A controller (software or a sequencer elsewhere) keeps the 80-word schedule and the round constants. It hands the block a 256-bit operand of four words and a second operand, and picks the step with an opcode bit. The *partial* step adds the small-sigma-0 term of each word's successor to that word. The *finish* step folds in small-sigma-1. Its upper two lanes depend on the lower two lanes computed in the same operation.

Operands enter through a valid/ready handshake. An operand is taken on a rising clock edge where `in_valid` and `in_ready` are both high. Results leave through a second valid/ready handshake. A result is consumed on an edge where `out_valid` and `out_ready` are both high. While `out_valid` is high and `out_ready` is low, the result and its valid flag hold. Once both pipeline stages are occupied and the output is stalled, `in_ready` is low. `in_ready` is combinationally dependent on `out_ready`.

The partial step takes one register stage. The finish step takes two: the dependent lanes are computed in the second stage. Results always leave in acceptance order. A partial result that finds an older finish result ahead of it waits one more stage behind it.

Top module: `sha512_sched_unit`

## Requirements
- R1: With `in_op`=0 (partial), result lane i (bits 64i+63:64i, i=0..3) equals operand-A lane i plus sig0 of A lane i+1. The word after lane 3 is `in_b[63:0]`. sig0(x) = ror(x,1) ^ ror(x,8) ^ (x>>7).
- R2: With `in_op`=0, `in_b[255:64]` has no effect on the result.
- R3: With `in_op`=1 (finish), result lanes 0 and 1 equal A lanes 0 and 1 plus sig1 of B lanes 2 and 3 respectively. sig1(x) = ror(x,19) ^ ror(x,61) ^ (x>>6).
- R4: With `in_op`=1, result lanes 2 and 3 equal A lanes 2 and 3 plus sig1 of result lanes 0 and 1 of the same operation.
- R5: All additions wrap modulo 2^64.
- R6: Consider an operand accepted while the pipeline is empty. A partial result is valid in the cycle after the accepting edge. A finish result is not valid then, and is valid one cycle later.
- R7: Every accepted operand produces exactly one result, and results leave in acceptance order.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid` and `out_data` hold at the next edge. With both stages occupied and the output stalled, `in_ready` is low.
- R9: A synchronous active-high `rst` clears both stages. After reset, `out_valid` is 0 and `in_ready` is 1.
- R10: While `out_ready` stays high, `in_ready` stays high, so one operand is accepted every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand offered |
| in_ready | output | 1 | Operand can be taken this cycle |
| in_op | input | 1 | 0 = partial step, 1 = finish step |
| in_a | input | 256 | Four 64-bit words, lane 0 in the low bits |
| in_b | input | 256 | Second operand; partial step reads only bits 63:0 |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | 256 | Four result words, lane 0 in the low bits |

## Verification
The hardest case to reach from the ports is a partial result stuck in the first stage behind a finish result held in the second stage. It must not exit early, and it must later move into the second stage as a plain pass-through. Reaching it needs a finish operand followed at once by a partial operand, while the consumer withholds `out_ready`. A directed stall sequence builds exactly this. A long random run then mixes opcodes, gaps in `in_valid` and a consumer that is ready about seventy percent of the time. Every result is matched in order against a queue of independently computed expected words.

// File: rtl/sha512_sched_pkg.sv
package sha512_sched_pkg;
  localparam int WORD_W = 64;
  localparam int LANES  = 4;
  localparam int HALF   = LANES / 2;
  localparam int VEC_W  = WORD_W * LANES;

  typedef enum logic {
    OP_PARTIAL = 1'b0,
    OP_FINISH  = 1'b1
  } sched_op_e;

  function automatic logic [WORD_W-1:0] rotr(input logic [WORD_W-1:0] x, input int n);
    return (x >> n) | (x << (WORD_W - n));
  endfunction

  function automatic logic [WORD_W-1:0] small_sig0(input logic [WORD_W-1:0] x);
    return rotr(x, 1) ^ rotr(x, 8) ^ (x >> 7);
  endfunction

  function automatic logic [WORD_W-1:0] small_sig1(input logic [WORD_W-1:0] x);
    return rotr(x, 19) ^ rotr(x, 61) ^ (x >> 6);
  endfunction
endpackage

// File: rtl/sched_sigma_add.sv
module sched_sigma_add
  import sha512_sched_pkg::*;
#(
  parameter bit USE_SIG1 = 1'b0
) (
  input  logic [WORD_W-1:0] base,
  input  logic [WORD_W-1:0] src,
  output logic [WORD_W-1:0] sum
);
  logic [WORD_W-1:0] mixed;

  generate
    if (USE_SIG1) begin : g_sig1
      assign mixed = small_sig1(src);
    end else begin : g_sig0
      assign mixed = small_sig0(src);
    end
  endgenerate

  // modulo 2^WORD_W by truncation of the sum
  assign sum = base + mixed;
endmodule

// File: rtl/sched_partial_lanes.sv
module sched_partial_lanes
  import sha512_sched_pkg::*;
(
  input  logic [VEC_W-1:0]  opa,
  input  logic [WORD_W-1:0] next_word,
  output logic [VEC_W-1:0]  res
);
  genvar i;
  generate
    for (i = 0; i < LANES; i++) begin : g_lane
      logic [WORD_W-1:0] succ;
      if (i == LANES - 1) begin : g_last
        assign succ = next_word;
      end else begin : g_mid
        assign succ = opa[(i+1)*WORD_W +: WORD_W];
      end
      sched_sigma_add #(.USE_SIG1(1'b0)) u_add (
        .base (opa[i*WORD_W +: WORD_W]),
        .src  (succ),
        .sum  (res[i*WORD_W +: WORD_W])
      );
    end
  endgenerate
endmodule

// File: rtl/sched_finish_front.sv
module sched_finish_front
  import sha512_sched_pkg::*;
(
  input  logic [VEC_W-1:0] opa,
  input  logic [VEC_W-1:0] opb,
  output logic [VEC_W-1:0] mid
);
  genvar i;
  generate
    for (i = 0; i < HALF; i++) begin : g_lo
      sched_sigma_add #(.USE_SIG1(1'b1)) u_add (
        .base (opa[i*WORD_W +: WORD_W]),
        .src  (opb[(i+HALF)*WORD_W +: WORD_W]),
        .sum  (mid[i*WORD_W +: WORD_W])
      );
    end
    for (i = HALF; i < LANES; i++) begin : g_hi
      assign mid[i*WORD_W +: WORD_W] = opa[i*WORD_W +: WORD_W];
    end
  endgenerate
endmodule

// File: rtl/sched_finish_back.sv
module sched_finish_back
  import sha512_sched_pkg::*;
(
  input  logic [VEC_W-1:0] mid,
  output logic [VEC_W-1:0] res
);
  genvar i;
  generate
    for (i = 0; i < HALF; i++) begin : g_lo
      assign res[i*WORD_W +: WORD_W] = mid[i*WORD_W +: WORD_W];
    end
    for (i = HALF; i < LANES; i++) begin : g_hi
      sched_sigma_add #(.USE_SIG1(1'b1)) u_add (
        .base (mid[i*WORD_W +: WORD_W]),
        .src  (mid[(i-HALF)*WORD_W +: WORD_W]),
        .sum  (res[i*WORD_W +: WORD_W])
      );
    end
  endgenerate
endmodule

// File: rtl/sha512_sched_unit.sv
module sha512_sched_unit
  import sha512_sched_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic             in_op,
  input  logic [VEC_W-1:0] in_a,
  input  logic [VEC_W-1:0] in_b,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [VEC_W-1:0] out_data
);
  logic [VEC_W-1:0] part_res, front_mid, back_res, s1_next;
  logic             s1_v, s2_v;
  sched_op_e        s1_op;
  logic [VEC_W-1:0] s1_d, s2_d, s2_next;
  logic             fire_out, s2_free, s2_take, s1_leave, s1_free;

  sched_partial_lanes u_part (
    .opa       (in_a),
    .next_word (in_b[WORD_W-1:0]),
    .res       (part_res)
  );

  sched_finish_front u_front (
    .opa (in_a),
    .opb (in_b),
    .mid (front_mid)
  );

  sched_finish_back u_back (
    .mid (s1_d),
    .res (back_res)
  );

  assign s1_next = (in_op == OP_FINISH) ? front_mid : part_res;
  assign s2_next = (s1_op == OP_FINISH) ? back_res : s1_d;

  // Output: second stage has priority (older); a partial result may exit from stage one
  assign out_valid = s2_v | (s1_v & (s1_op == OP_PARTIAL));
  assign out_data  = s2_v ? s2_d : s1_d;
  assign fire_out  = out_valid & out_ready;

  assign s2_free  = ~s2_v | fire_out;
  assign s2_take  = s1_v & ((s1_op == OP_FINISH) | s2_v);
  assign s1_leave = s1_v & (s2_take ? s2_free : fire_out);
  assign s1_free  = ~s1_v | s1_leave;
  assign in_ready = s1_free;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_v <= 1'b0;
    end else if (s1_free) begin
      s1_v <= in_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (s1_free && in_valid) begin
      s1_op <= sched_op_e'(in_op);
      s1_d  <= s1_next;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s2_v <= 1'b0;
    end else if (s2_free) begin
      s2_v <= s2_take;
    end
  end

  always_ff @(posedge clk) begin
    if (s2_free && s2_take) begin
      s2_d <= s2_next;
    end
  end

  // R9
  reset_clear_chk: assert property (@(posedge clk) rst |=> (!out_valid && in_ready));

  // R8
  out_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  // R8
  full_stall_chk: assert property (@(posedge clk) disable iff (rst)
    (s1_v && s2_v && !out_ready) |-> !in_ready);

  // R6
  partial_lat_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && in_op == OP_PARTIAL && !s1_v && !s2_v) |=> out_valid);

  // R6
  finish_lat_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && in_op == OP_FINISH && !s1_v && !s2_v) |=> (!out_valid ##1 out_valid));

  // R10
  no_bubble_chk: assert property (@(posedge clk) disable iff (rst)
    out_ready |-> in_ready);
endmodule

// File: tb/tb_sha512_sched_unit.sv
module tb_sha512_sched_unit;
  localparam int CLK_PERIOD = 10;
  localparam int VW = 256;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0, in_op = 1'b0, out_ready = 1'b0;
  logic [VW-1:0] in_a = '0, in_b = '0;
  logic          in_ready, out_valid;
  logic [VW-1:0] out_data;

  int checks = 0, failures = 0;
  logic [VW-1:0] exp_q[$];
  string         tag_q[$];
  logic          prev_stall = 1'b0;
  logic [VW-1:0] prev_data = '0;
  logic          last_in_ready, last_out_valid;

  always #(CLK_PERIOD/2) clk = ~clk;

  sha512_sched_unit dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .in_op(in_op),
    .in_a(in_a), .in_b(in_b), .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  function automatic logic [63:0] rr(input logic [63:0] x, input int n);
    return {x, x} >> n;
  endfunction
  function automatic logic [63:0] f0(input logic [63:0] x);
    return rr(x, 1) ^ rr(x, 8) ^ (x >> 7);
  endfunction
  function automatic logic [63:0] f1(input logic [63:0] x);
    return rr(x, 19) ^ rr(x, 61) ^ (x >> 6);
  endfunction
  function automatic logic [63:0] ln(input logic [VW-1:0] v, input int k);
    return v[k*64 +: 64];
  endfunction
  function automatic logic [VW-1:0] ref_partial(input logic [VW-1:0] a, input logic [VW-1:0] b);
    logic [63:0] w0, w1, w2, w3;
    w0 = ln(a,0) + f0(ln(a,1));
    w1 = ln(a,1) + f0(ln(a,2));
    w2 = ln(a,2) + f0(ln(a,3));
    w3 = ln(a,3) + f0(b[63:0]);
    return {w3, w2, w1, w0};
  endfunction
  function automatic logic [VW-1:0] ref_finish(input logic [VW-1:0] a, input logic [VW-1:0] b);
    logic [63:0] n0, n1, n2, n3;
    n0 = ln(a,0) + f1(ln(b,2));
    n1 = ln(a,1) + f1(ln(b,3));
    n2 = ln(a,2) + f1(n0);
    n3 = ln(a,3) + f1(n1);
    return {n3, n2, n1, n0};
  endfunction

  function automatic logic [VW-1:0] rnd256();
    return {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom};
  endfunction

  task automatic check(input logic ok, input string req, input logic [VW-1:0] act, input logic [VW-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic v, input logic op, input logic [VW-1:0] a,
                      input logic [VW-1:0] b, input logic ordy);
    @(negedge clk);
    in_valid = v; in_op = op; in_a = a; in_b = b; out_ready = ordy;
    #1;
    if (prev_stall)
      check(out_valid && out_data == prev_data, "R8 hold", out_data, prev_data);
    if (out_valid && out_ready) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R7 extra result", out_data, '0);
      end else begin
        logic [VW-1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(out_data == e, t, out_data, e);
      end
    end
    if (in_valid && in_ready) begin
      exp_q.push_back(op ? ref_finish(a, b) : ref_partial(a, b));
      tag_q.push_back(op ? "R3 R4 R5 R7" : "R1 R2 R5 R7");
    end
    prev_stall = out_valid && !out_ready;
    prev_data = out_data;
    last_in_ready = in_ready;
    last_out_valid = out_valid;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, '0, '0, 1'b1);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=0", 1);
    finish_run();
  end

  initial begin
    logic [VW-1:0] a, b, ones;
    void'($urandom(32'd20240611));
    ones = '1;
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;

    // R9 reset state
    step(1'b0, 1'b0, '0, '0, 1'b0);
    check(!last_out_valid, "R9 out_valid", {255'd0, last_out_valid}, '0);
    check(last_in_ready, "R9 in_ready", {255'd0, last_in_ready}, 256'd1);

    // R6 partial latency into empty pipe
    a = rnd256(); b = rnd256();
    step(1'b1, 1'b0, a, b, 1'b1);
    check(last_in_ready, "R6 accept", {255'd0, last_in_ready}, 256'd1);
    step(1'b0, 1'b0, '0, '0, 1'b1);
    check(last_out_valid, "R6 partial one cycle", {255'd0, last_out_valid}, 256'd1);
    idle(2);

    // R6 finish latency into empty pipe
    step(1'b1, 1'b1, rnd256(), rnd256(), 1'b1);
    step(1'b0, 1'b0, '0, '0, 1'b1);
    check(!last_out_valid, "R6 finish not early", {255'd0, last_out_valid}, '0);
    step(1'b0, 1'b0, '0, '0, 1'b1);
    check(last_out_valid, "R6 finish two cycles", {255'd0, last_out_valid}, 256'd1);
    idle(2);

    // R5 wrap corners, zero vectors, R2 upper bits of B differ
    step(1'b1, 1'b0, ones, ones, 1'b1);
    step(1'b1, 1'b1, ones, ones, 1'b1);
    step(1'b1, 1'b0, '0, '0, 1'b1);
    step(1'b1, 1'b1, '0, '0, 1'b1);
    a = rnd256(); b = rnd256();
    step(1'b1, 1'b0, a, {192'd0, b[63:0]}, 1'b1);
    step(1'b1, 1'b0, a, {ones[191:0], b[63:0]}, 1'b1);
    // R4 chain: A zero, so upper lanes equal sig1 of sig1 of B lanes
    step(1'b1, 1'b1, '0, rnd256(), 1'b1);
    idle(3);

    // R8 back-pressure: finish then partial, output stalled
    step(1'b1, 1'b1, rnd256(), rnd256(), 1'b0);
    step(1'b1, 1'b0, rnd256(), rnd256(), 1'b0);
    for (int i = 0; i < 4; i++) begin
      step(1'b1, 1'b1, rnd256(), rnd256(), 1'b0);
      check(!last_in_ready, "R8 in_ready low when full", {255'd0, last_in_ready}, '0);
    end
    idle(4);

    // R10 full throughput with ready consumer
    for (int i = 0; i < 24; i++) begin
      step(1'b1, 1'($urandom % 2), rnd256(), rnd256(), 1'b1);
      check(last_in_ready, "R10 in_ready", {255'd0, last_in_ready}, 256'd1);
    end
    idle(3);

    // Random mix with back-pressure (R7 ordering)
    for (int i = 0; i < 3000; i++) begin
      step(($urandom % 4) != 0, 1'($urandom % 2), rnd256(), rnd256(), ($urandom % 10) < 7);
    end
    idle(8);
    check(exp_q.size() == 0, "R7 all results delivered", VW'(exp_q.size()), '0);

    finish_run();
  end
endmodule